// File: doc/BRIEF.md
# Register-Programmed MDIO Management Master

This block drives the two-wire station management bus used to configure Ethernet PHYs. A host reaches it through four 32-bit word registers: configuration, address, data and operation. Writing the operation register while the engine is idle launches exactly one serial frame on MDC/MDIO. The host polls a busy bit until the frame is finished. After a read, it collects the returned 16-bit value from the data register.

One shift engine produces both frame styles. The start code taken from the configuration register decides how the far end reads the frame. The value 01 gives the classic direct frame, where opcode 01 writes and 10 reads. The value 00 gives the extended indirect frame, where opcodes 00, 01, 10 and 11 mean address, write, read-with-post-increment and read. In both styles the two operation bits are sent unchanged as the opcode. Bit 1 of the operation decides whether the master releases the line for a turnaround and a data phase from the PHY. Several further features are programmable: a 32-bit all-ones preamble that can be left out, the MDC divider, gating and inversion of the sampled input, and a post-frame increment of the local register-address field.

Top module: `mdio_master`

## Requirements
- R1: After synchronous reset, all four registers read as zero, MDC is low and MDIO is not driven.
- R2: MDC idles low. While a frame runs, MDC has a period of 2*(div+1) system clocks, where div is configuration bits 12:5. Its first rising edge comes div+1 clocks after the accepted operation write.
- R3: With configuration bit 2 set, a frame opens with 32 ones before the start code, so it is 64 MDC cycles long. With the bit clear, it begins at the start code and lasts 32 MDC cycles.
- R4: After the optional preamble, the frame carries these fields MSB first: the start code from configuration bits 4:3, the opcode from operation bits 1:0, the PHY address from address bits 9:5, and the register address from address bits 4:0. MDIO changes only when MDC falls.
- R5: When operation bit 1 is 0 (write or address), the master drives the whole frame, ending with turnaround bits 1 then 0 and then data register bits 15:0.
- R6: When operation bit 1 is 1 (a read), the master releases MDIO for the two turnaround bits and the 16 data bits. It samples the data MSB first on each MDC rise and stores the value into data register bits 15:0 when the frame ends.
- R7: Configuration bit 0 gates the sampled input, so a clear bit reads all zeros. Configuration bit 1 inverts each sampled bit.
- R8: Operation bit 31 reads 1 from the clock after the accepted write until the last MDC fall of the frame.
- R9: A write to the operation register while busy changes neither the running frame nor the stored operation bits.
- R10: With operation bit 2 set, the register-address field (address bits 4:0) rises by one after each frame and wraps from 31 to 0. The PHY field is unchanged. With bit 2 clear, the address register stays the same.
- R11: Word index 0 holds configuration bits 12:0, index 1 holds address bits 9:0, index 2 holds data bits 15:0, and index 3 holds operation bits 2:0 with busy in bit 31. All other read bits are zero, and read data appears one clock after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word index: 0 config, 1 address, 2 data, 3 operation |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | High while the master drives MDIO |
| mdio_in | input | 1 | Serial data returned from the PHY |

## Verification
The bench builds the block with its default parameters, DIV_W=8 and PRE_LEN=32. It programs only small divider values at run time, which keeps every frame to a few hundred clocks. That budget lets the bench sweep every start code and opcode pair, both preamble settings, two dividers, and the input gate and inversion settings. Each of these frames is compared bit by bit with a frame built arithmetically in the bench. Separate runs cover the register-address wrap from 31 to 0 and an operation write issued in the middle of a frame.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  typedef enum logic [1:0] {
    RG_CFG  = 2'd0,
    RG_ADDR = 2'd1,
    RG_DATA = 2'd2,
    RG_OP   = 2'd3
  } reg_sel_e;

  localparam int BODY_W    = 32;
  localparam int DATA_W    = 16;
  localparam int FLD_W     = 5;
  localparam logic [1:0] TA_DRIVE = 2'b10;
  localparam logic [1:0] TA_FREE  = 2'b11;
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             hit;

  assign hit  = run && (cnt == div);
  assign rise = hit && !mdc;
  assign fall = hit && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt == div) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pre_en,
  input  logic [1:0]        st_code,
  input  logic [1:0]        op,
  input  logic              in_en,
  input  logic              in_inv,
  input  logic [FLD_W-1:0]  phy_ad,
  input  logic [FLD_W-1:0]  reg_ad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_in,
  output logic              busy,
  output logic              done,
  output logic              done_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              mdio_out,
  output logic              mdio_oe
);
  localparam int FRAME_W = PRE_LEN + BODY_W;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_OUT = IDX_W'(DATA_W + 1);

  logic [FRAME_W-1:0] sreg;
  logic [IDX_W-1:0]   idx;
  logic               rd_q, en_q, inv_q;
  logic [BODY_W-1:0]  body;
  logic               smp;

  assign body    = {st_code, op, phy_ad, reg_ad, (op[1] ? TA_FREE : TA_DRIVE), wdata};
  assign smp     = en_q & (mdio_in ^ inv_q);
  assign done_rd = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      sreg     <= '0;
      idx      <= '0;
      rd_q     <= 1'b0;
      en_q     <= 1'b0;
      inv_q    <= 1'b0;
      rx_data  <= '0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        rd_q    <= op[1];
        en_q    <= in_en;
        inv_q   <= in_inv;
        rx_data <= '0;
        mdio_oe <= 1'b1;
        if (pre_en) begin
          sreg     <= {{PRE_LEN{1'b1}}, body};
          idx      <= IDX_W'(FRAME_W - 1);
          mdio_out <= 1'b1;
        end else begin
          sreg     <= {body, {PRE_LEN{1'b0}}};
          idx      <= IDX_W'(BODY_W - 1);
          mdio_out <= st_code[1];
        end
      end else if (busy) begin
        if (rise && rd_q && (idx < IDX_W'(DATA_W)))
          rx_data <= {rx_data[DATA_W-2:0], smp};
        if (fall) begin
          if (idx == '0) begin
            busy     <= 1'b0;
            done     <= 1'b1;
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b0;
          end else begin
            idx      <= idx - 1'b1;
            sreg     <= sreg << 1;
            mdio_out <= sreg[FRAME_W-2];
            mdio_oe  <= !(rd_q && ((idx - 1'b1) <= LAST_OUT));
          end
        end
      end
    end
  end

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && (idx < IDX_W'(DATA_W))) |-> !mdio_oe) else $error("read phase driven"); // R6
  AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe) else $error("driven while idle"); // R8
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int CFG_W  = 5 + DIV_W;
  localparam int ADDR_W = 2 * FLD_W;

  logic [CFG_W-1:0]  cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [2:0]        op_q;
  logic              busy, done, done_rd, rise, fall, start;
  logic [DATA_W-1:0] rx_data;

  assign start = bus_wr && (bus_addr == RG_OP) && !busy;

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .div(cfg_q[5 +: DIV_W]),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst(rst), .start(start),
    .pre_en(cfg_q[2]), .st_code(cfg_q[4:3]), .op(bus_wdata[1:0]),
    .in_en(cfg_q[0]), .in_inv(cfg_q[1]),
    .phy_ad(addr_q[2*FLD_W-1:FLD_W]), .reg_ad(addr_q[FLD_W-1:0]),
    .wdata(data_q), .rise(rise), .fall(fall), .mdio_in(mdio_in),
    .busy(busy), .done(done), .done_rd(done_rd), .rx_data(rx_data),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      op_q   <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          RG_CFG:  cfg_q  <= bus_wdata[CFG_W-1:0];
          RG_ADDR: addr_q <= bus_wdata[ADDR_W-1:0];
          RG_DATA: data_q <= bus_wdata[DATA_W-1:0];
          default: if (!busy) op_q <= bus_wdata[2:0];
        endcase
      end
      if (done) begin
        if (done_rd) data_q <= rx_data;
        if (op_q[2] && !(bus_wr && bus_addr == RG_ADDR))
          addr_q[FLD_W-1:0] <= addr_q[FLD_W-1:0] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        RG_CFG:  bus_rdata <= 32'(cfg_q);
        RG_ADDR: bus_rdata <= 32'(addr_q);
        RG_DATA: bus_rdata <= 32'(data_q);
        default: bus_rdata <= {busy, 28'd0, op_q};
      endcase
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc) else $error("mdc active while idle"); // R2
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$fell(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)))
    else $error("mdio moved off falling edge"); // R4
  AST_OP_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(op_q)) else $error("op changed while busy"); // R9
  AST_AUTOINC: assert property (@(posedge clk) disable iff (rst)
    ($past(done) && $past(op_q[2]) && !$past(bus_wr && bus_addr == RG_ADDR))
      |-> (addr_q[FLD_W-1:0] == $past(addr_q[FLD_W-1:0]) + 1'b1))
    else $error("register address not advanced"); // R10
endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int  n_chk = 0;
  int  n_err = 0;
  time t_wr;

  always #10 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    t_wr = $time;
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    @(posedge clk);
    #1;
    v = bus_rdata;
  endtask

  task automatic run_frame(input logic [1:0] st, input logic [1:0] op, input bit ai,
                           input int div, input bit pre, input bit en, input bit inv,
                           input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] pat, input bit poke);
    int          nb;
    bit          rd;
    logic [31:0] body, v;
    logic [15:0] exp_data;
    time         t0, t_first, t_last;
    int          bit_err, oe_err, busy_err;
    bit          exp_oe, exp_b;
    rd   = op[1];
    nb   = pre ? 64 : 32;
    body = {st, op, phy, rg, 2'b10, wd};
    bit_err = 0; oe_err = 0; busy_err = 0;
    t_first = 0; t_last = 0;
    bus_write(2'd0, {19'h7FFFF, div[7:0], st, pre, inv, en});
    bus_write(2'd1, {22'h3FFFFF, phy, rg});
    bus_write(2'd2, {16'hFFFF, wd});
    mdio_in = 1'b1;
    bus_write(2'd3, {1'b1, 28'hFFFFFFF, ai, op});
    t0 = t_wr;
    for (int k = 0; k < nb; k++) begin
      int rem;
      rem = nb - 1 - k;
      mdio_in = (rd && rem <= 15) ? pat[rem] : 1'b1;
      @(posedge mdc);
      if (k == 0) t_first = $time;
      t_last = $time;
      #1;
      exp_oe = !(rd && rem <= 17);
      if (mdio_oe !== exp_oe) oe_err++;
      if (exp_oe) begin
        exp_b = (pre && k < 32) ? 1'b1 : body[rem];
        if (mdio_out !== exp_b) bit_err++;
      end
      if (bus_rdata[31] !== 1'b1) busy_err++;
      if (poke && k == 10) bus_write(2'd3, {29'd0, ~ai, ~op});
      if (k < nb - 1) begin
        @(negedge mdc);
        #1;
      end
    end
    for (int w = 0; w < 2000 && bus_rdata[31] === 1'b1; w++) begin
      @(posedge clk);
      #1;
    end
    check(pre ? "R3 R4 frame bits" : "R4 frame bits", 32'(bit_err), 32'd0);
    check(rd ? "R6 release window" : "R5 drive window", 32'(oe_err), 32'd0);
    check("R8 busy during frame", 32'(busy_err), 32'd0);
    check("R2 first rise delay", 32'(t_first - t0), 32'((div + 1) * 20));
    check(pre ? "R3 frame length" : "R2 frame length", 32'(t_last - t_first),
          32'((nb - 1) * 2 * (div + 1) * 20));
    exp_data = rd ? (en ? (inv ? ~pat : pat) : 16'h0000) : wd;
    bus_read(2'd2, v);
    check(rd ? ((en && !inv) ? "R6 read data" : "R7 read data") : "R5 data kept",
          v, {16'd0, exp_data});
    bus_read(2'd1, v);
    check("R10 address after frame", v, {22'd0, phy, ai ? 5'(rg + 5'd1) : rg});
    bus_read(2'd3, v);
    check(poke ? "R9 op unchanged" : "R11 op readback", v, {1'b0, 28'd0, ai, op});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1: reset values
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), v);
      check("R1 register reset", v, 32'd0);
    end
    check("R1 mdc idle", {31'd0, mdc}, 32'd0);
    check("R1 mdio released", {31'd0, mdio_oe}, 32'd0);
    // R11: config readback masks upper bits
    bus_write(2'd0, 32'hFFFF_E5A5);
    bus_read(2'd0, v);
    check("R11 config readback", v, 32'h0000_05A5);
    // sweep of start codes, opcodes, dividers and preamble
    n = 0;
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 4; o++) begin
        if (s == 1 && (o == 0 || o == 3)) continue;
        for (int d = 0; d < 2; d++)
          for (int p = 0; p < 2; p++) begin
            run_frame(s ? 2'b01 : 2'b00, 2'(o), n[0], d * 2, p[0], (n % 3) != 0, n[1],
                      5'(n * 7), 5'(n * 3), 16'(n * 16'h3A1F + 1),
                      16'(16'hC35A ^ (n * 16'h00F1)), 1'b0);
            n++;
          end
      end
    // R10: wrap of the register-address field
    run_frame(2'b01, 2'b01, 1'b1, 1, 1'b0, 1'b1, 1'b0, 5'd9, 5'd31, 16'hBEEF, 16'h0, 1'b0);
    // R9: operation write during a frame
    run_frame(2'b00, 2'b11, 1'b0, 3, 1'b0, 1'b1, 1'b0, 5'd17, 5'd4, 16'h0F0F, 16'h96E1, 1'b1);
    // R7: gated and inverted input
    run_frame(2'b01, 2'b10, 1'b0, 1, 1'b1, 1'b0, 1'b1, 5'd1, 5'd2, 16'h1111, 16'hFFFF, 1'b0);
    run_frame(2'b01, 2'b10, 1'b0, 1, 1'b0, 1'b1, 1'b1, 5'd3, 5'd5, 16'h2222, 16'h8001, 1'b0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule